// File: doc/BRIEF.md
# Autonegotiation link timer unit

This unit sits on the PCS side of a serial gigabit link and keeps the small set of configuration registers that steer autonegotiation: a control word, an interface-mode word, a local ability word and a link-timer count spread over a low and a high 16-bit register. All of them are reached through a simple register port with a 5-bit address, a write strobe, write data and combinational read data, in the manner of a management register space.

Writing the restart bit of the control word while autonegotiation is enabled starts a cycle counter from zero. The counter runs up to the link-timer count that was programmed when it started, then raises a one-cycle expiry pulse and stops. Typical counts are 0x07A120 for a 1.6 ms SGMII timer and 0x2FAF08 for a 10 ms 1000BASE-X timer at 312.5 MHz. When autonegotiation is disabled the link is fixed: the timer stays idle and the unit reports the speed and duplex that the interface-mode word selects.

Top module: `anlt_unit`

## Requirements
- R1: After reset the registers read: control (0x00) 0x1140, ability (0x04) 0x4001, timer low (0x12) 0xA120, timer high (0x13) 0x0007, interface mode (0x14) 0x0003; the timer is idle with no expiry, and fixed_link is 0.
- R2: The five addresses above are readable and writable; the timer-high register keeps only its 6 low bits and reads 0 above them; any other address reads 0 and a write to it changes no register.
- R3: Control bit 9 (restart) reads 1 in the cycle after a write that sets it and reads 0 one cycle later unless it is written again.
- R4: When control bit 12 (autonegotiation enable) is 1, a restart sets an_timer_busy from the cycle after the restart bit is seen.
- R5: With a programmed count L = {high[5:0], low}, an_timer_expired is 1 for exactly one cycle, L+2 cycles after the clock edge that sampled the restart write; an_timer_busy is 0 in that cycle.
- R6: A restart while the timer is running restarts the count from zero, so the expiry follows L+2 cycles after the newest restart write.
- R7: Writing the timer registers while the timer runs does not change the current run; the new count applies from the next restart.
- R8: While control bit 12 is 0 a restart does not start the timer, and clearing bit 12 during a run stops the timer with no expiry.
- R9: fixed_link is the inverse of control bit 12; while it is 1, link_speed is 2 (1G) if interface-mode bit 3 is set, else 1 (100M) if bit 2 is set, else 0 (10M), and link_full_duplex is the inverse of interface-mode bit 4; while fixed_link is 0 both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (link-side reference) |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Register address for reads and writes |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| an_timer_busy | output | 1 | Link timer is counting |
| an_timer_expired | output | 1 | One-cycle pulse at link-timer expiry |
| fixed_link | output | 1 | Autonegotiation bypassed, speed and duplex are valid |
| link_speed | output | 2 | 0 = 10M, 1 = 100M, 2 = 1G |
| link_full_duplex | output | 1 | Full duplex in fixed-link mode |

## Verification
The assertions assume that reset is held low long enough to clear every register and that the write strobe, address and data are settled around each rising edge, so every register change follows from one sampled write. The bench drives all port inputs at the falling edge and holds reg_we for exactly one rising edge per write, never touching a register in the same cycle the timer is expected to expire. Timer counts are kept small, with one run above 65535 to exercise the high register, so every run ends well within the bench's cycle budget.

// File: rtl/anlt_pkg.sv
package anlt_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 5;

    // Register addresses
    localparam logic [ADDR_W-1:0] ADR_CTL  = 5'h00;
    localparam logic [ADDR_W-1:0] ADR_ABIL = 5'h04;
    localparam logic [ADDR_W-1:0] ADR_TLO  = 5'h12;
    localparam logic [ADDR_W-1:0] ADR_THI  = 5'h13;
    localparam logic [ADDR_W-1:0] ADR_IFM  = 5'h14;

    // Control word bits
    localparam int CTL_AN_EN_BIT   = 12;
    localparam int CTL_RESTART_BIT = 9;

    // Interface-mode word bits
    localparam int IFM_100M_BIT = 2;
    localparam int IFM_1G_BIT   = 3;
    localparam int IFM_HALF_BIT = 4;

    typedef enum logic [1:0] {
        SPD_10M  = 2'd0,
        SPD_100M = 2'd1,
        SPD_1G   = 2'd2
    } speed_e;

endpackage

// File: rtl/anlt_regfile.sv
module anlt_regfile
    import anlt_pkg::*;
#(
    parameter int                 TMR_W    = 22,
    parameter logic [REG_W-1:0]   RST_CTL  = 16'h1140,
    parameter logic [REG_W-1:0]   RST_ABIL = 16'h4001,
    parameter logic [REG_W-1:0]   RST_IFM  = 16'h0003,
    parameter logic [TMR_W-1:0]   RST_TMR  = 22'h07A120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              an_en,
    output logic              restart_req,
    output logic [2:0]        mode_bits,
    output logic [TMR_W-1:0]  tmr_limit
);

    localparam int HI_W = TMR_W - REG_W;

    typedef struct packed {
        logic [REG_W-1:0] ctl;
        logic [REG_W-1:0] abil;
        logic [REG_W-1:0] tlo;
        logic [HI_W-1:0]  thi;
        logic [REG_W-1:0] ifm;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        regs_d.ctl[CTL_RESTART_BIT] = 1'b0;
        if (wr_en) begin
            case (addr)
                ADR_CTL:  regs_d.ctl  = wdata;
                ADR_ABIL: regs_d.abil = wdata;
                ADR_TLO:  regs_d.tlo  = wdata;
                ADR_THI:  regs_d.thi  = wdata[HI_W-1:0];
                ADR_IFM:  regs_d.ifm  = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.ctl  <= RST_CTL;
            regs_q.abil <= RST_ABIL;
            regs_q.tlo  <= RST_TMR[REG_W-1:0];
            regs_q.thi  <= RST_TMR[TMR_W-1:REG_W];
            regs_q.ifm  <= RST_IFM;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (addr)
            ADR_CTL:  rdata = regs_q.ctl;
            ADR_ABIL: rdata = regs_q.abil;
            ADR_TLO:  rdata = regs_q.tlo;
            ADR_THI:  rdata = {{(REG_W-HI_W){1'b0}}, regs_q.thi};
            ADR_IFM:  rdata = regs_q.ifm;
            default:  rdata = '0;
        endcase
    end

    assign an_en       = regs_q.ctl[CTL_AN_EN_BIT];
    assign restart_req = regs_q.ctl[CTL_RESTART_BIT];
    assign mode_bits   = regs_q.ifm[IFM_HALF_BIT:IFM_100M_BIT];
    assign tmr_limit   = {regs_q.thi, regs_q.tlo};

    // R3: restart bit lives for one cycle unless rewritten
    assert_restart_selfclear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_req && !(wr_en && addr == ADR_CTL && wdata[CTL_RESTART_BIT]))
        |=> !restart_req);

    // R2: a write to an unmapped address leaves the timer count unchanged
    assert_unmapped_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != ADR_TLO && addr != ADR_THI) |=> $stable(tmr_limit));

endmodule

// File: rtl/anlt_timer.sv
module anlt_timer #(
    parameter int TMR_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             an_en,
    input  logic             start,
    input  logic [TMR_W-1:0] limit,
    output logic             busy,
    output logic             expired
);

    localparam logic [TMR_W-1:0] CNT_ONE = {{(TMR_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
        logic [TMR_W-1:0] lim;
        logic             run;
        logic             exp;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d     = tmr_q;
        tmr_d.exp = 1'b0;
        if (!an_en) begin
            tmr_d.run = 1'b0;
        end else if (start) begin
            tmr_d.cnt = '0;
            tmr_d.lim = limit;
            tmr_d.run = 1'b1;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == tmr_q.lim) begin
                tmr_d.run = 1'b0;
                tmr_d.exp = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy    = tmr_q.run;
    assign expired = tmr_q.exp;

    // R5: expiry is a single-cycle pulse
    assert_single_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.exp |=> !tmr_q.exp);

    // R5: the count never passes the latched limit
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.run |-> (tmr_q.cnt <= tmr_q.lim));

    // R5: expiry only follows a run that was in progress
    assert_expiry_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_q.exp) |-> ($past(tmr_q.run) && !tmr_q.run));

    // R4: an uninterrupted run advances by one each cycle
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.run && an_en && !start && tmr_q.cnt != tmr_q.lim)
        |=> (tmr_q.cnt == $past(tmr_q.cnt) + CNT_ONE));

    // R6: a restart reloads the count from zero
    assert_restart_from_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (an_en && start) |=> (tmr_q.run && tmr_q.cnt == '0));

    // R7: the limit in use holds for the whole run
    assert_limit_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.run && !start) |=> $stable(tmr_q.lim));

    // R8: with autonegotiation off the timer is quiet
    assert_bypass_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !an_en |=> (!tmr_q.run && !tmr_q.exp));

endmodule

// File: rtl/anlt_mode_resolve.sv
module anlt_mode_resolve
    import anlt_pkg::*;
(
    input  logic       an_en,
    input  logic [2:0] mode_bits,   // [0]=100M, [1]=1G, [2]=half duplex
    output logic       fixed,
    output logic [1:0] speed,
    output logic       full_dup
);

    speed_e spd;

    always_comb begin
        spd      = SPD_10M;
        full_dup = 1'b0;
        if (!an_en) begin
            if (mode_bits[1]) begin
                spd = SPD_1G;
            end else if (mode_bits[0]) begin
                spd = SPD_100M;
            end
            full_dup = !mode_bits[2];
        end
    end

    assign fixed = !an_en;
    assign speed = spd;

endmodule

// File: rtl/anlt_unit.sv
module anlt_unit
    import anlt_pkg::*;
#(
    parameter int               TMR_W    = 22,
    parameter logic [15:0]      RST_CTL  = 16'h1140,
    parameter logic [15:0]      RST_ABIL = 16'h4001,
    parameter logic [15:0]      RST_IFM  = 16'h0003,
    parameter logic [TMR_W-1:0] RST_TMR  = 22'h07A120
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  reg_addr,
    input  logic        reg_we,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        an_timer_busy,
    output logic        an_timer_expired,
    output logic        fixed_link,
    output logic [1:0]  link_speed,
    output logic        link_full_duplex
);

    logic             an_en;
    logic             restart_req;
    logic [2:0]       mode_bits;
    logic [TMR_W-1:0] tmr_limit;

    anlt_regfile #(
        .TMR_W    (TMR_W),
        .RST_CTL  (RST_CTL),
        .RST_ABIL (RST_ABIL),
        .RST_IFM  (RST_IFM),
        .RST_TMR  (RST_TMR)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_we),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .an_en       (an_en),
        .restart_req (restart_req),
        .mode_bits   (mode_bits),
        .tmr_limit   (tmr_limit)
    );

    anlt_timer #(
        .TMR_W (TMR_W)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .an_en   (an_en),
        .start   (restart_req),
        .limit   (tmr_limit),
        .busy    (an_timer_busy),
        .expired (an_timer_expired)
    );

    anlt_mode_resolve mode_i (
        .an_en    (an_en),
        .mode_bits(mode_bits),
        .fixed    (fixed_link),
        .speed    (link_speed),
        .full_dup (link_full_duplex)
    );

    // R9: link outputs stay zero while autonegotiation runs
    assert_an_outputs_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fixed_link |-> (link_speed == 2'd0 && !link_full_duplex));

    // R8: the timer never runs in fixed-link mode
    assert_fixed_no_timer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fixed_link && $past(fixed_link)) |-> (!an_timer_busy && !an_timer_expired));

endmodule

// File: tb/anlt_unit_tb.sv
module anlt_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        busy, expired, fixed_link, full_dup;
    logic [1:0]  speed;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    anlt_unit dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .reg_addr         (reg_addr),
        .reg_we           (reg_we),
        .reg_wdata        (reg_wdata),
        .reg_rdata        (reg_rdata),
        .an_timer_busy    (busy),
        .an_timer_expired (expired),
        .fixed_link       (fixed_link),
        .link_speed       (speed),
        .link_full_duplex (full_dup)
    );

    // {timer count, interface mode, expected speed, expected full duplex}
    localparam logic [40:0] VECS [0:4] = '{
        {22'd0,       16'h0009, 2'd2, 1'b1},
        {22'd1,       16'h0005, 2'd1, 1'b1},
        {22'd5,       16'h0011, 2'd0, 1'b0},
        {22'd63,      16'h001D, 2'd2, 1'b0},
        {22'h010007,  16'h0001, 2'd0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_timer(input logic [21:0] l);
        wr(5'h12, l[15:0]);
        wr(5'h13, {10'd0, l[21:16]});
    endtask

    // counts falling edges from now until expiry is seen
    task automatic wait_expiry(input int cap, output int n);
        n = 0;
        while (!expired && n < cap) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] r;
        int n;
        logic seen;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(5'h00, r); chk("R1 ctl", r, 16'h1140);
        rd(5'h04, r); chk("R1 abil", r, 16'h4001);
        rd(5'h12, r); chk("R1 tlo", r, 16'hA120);
        rd(5'h13, r); chk("R1 thi", r, 16'h0007);
        rd(5'h14, r); chk("R1 ifm", r, 16'h0003);
        chk("R1 busy", busy, 0);
        chk("R1 expired", expired, 0);
        chk("R1 fixed_link", fixed_link, 0);
        @(negedge clk);

        // Table walk: fixed-link decode (R9) and expiry timing (R3, R5)
        for (int i = 0; i < 5; i++) begin
            wr(5'h14, VECS[i][18:3]);
            wr(5'h00, 16'h0140);
            chk("R9 fixed_link", fixed_link, 1);
            chk("R9 speed", speed, VECS[i][2:1]);
            chk("R9 duplex", full_dup, VECS[i][0]);
            set_timer(VECS[i][40:19]);
            wr(5'h00, 16'h1340);
            rd(5'h00, r);
            chk("R3 restart set", r[9], 1);
            chk("R9 an speed", speed, 0);
            chk("R9 an duplex", full_dup, 0);
            wait_expiry(VECS[i][40:19] + 10, n);
            chk("R5 expiry cycle", n, VECS[i][40:19] + 2);
            chk("R5 busy at expiry", busy, 0);
            @(negedge clk);
            chk("R5 single pulse", expired, 0);
        end

        // R2: high register width, unmapped addresses, ability write
        wr(5'h13, 16'hFFFF);
        rd(5'h13, r); chk("R2 thi mask", r, 16'h003F);
        wr(5'h05, 16'hBEEF);
        rd(5'h05, r); chk("R2 unmapped read", r, 0);
        rd(5'h00, r); chk("R2 ctl untouched", r, 16'h1340 & 16'hFDFF);
        rd(5'h12, r); chk("R2 tlo untouched", r, 16'h0007);
        wr(5'h04, 16'h01A0);
        rd(5'h04, r); chk("R2 abil", r, 16'h01A0);

        // R3, R4: restart clears itself, timer starts
        set_timer(22'd20);
        wr(5'h00, 16'h1340);
        @(negedge clk);
        rd(5'h00, r); chk("R3 restart cleared", r[9], 0);
        chk("R4 busy", busy, 1);

        // R6: restart mid-run reloads from zero
        repeat (9) @(negedge clk);
        wr(5'h00, 16'h1340);
        wait_expiry(40, n);
        chk("R6 reload expiry", n, 22);
        @(negedge clk);

        // R7: timer write during run applies only to the next run
        set_timer(22'd30);
        wr(5'h00, 16'h1340);
        repeat (3) @(negedge clk);
        wr(5'h12, 16'd5);
        wait_expiry(60, n);
        chk("R7 current run unchanged", n + 4, 32);
        @(negedge clk);
        wr(5'h00, 16'h1340);
        wait_expiry(60, n);
        chk("R7 next run uses new count", n, 7);
        @(negedge clk);

        // R8: restart ignored with autonegotiation off
        wr(5'h00, 16'h0340);
        seen = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (busy || expired) seen = 1'b1;
        end
        chk("R8 no run when off", seen, 0);

        // R8: disabling mid-run stops without expiry
        set_timer(22'd10);
        wr(5'h00, 16'h1340);
        repeat (2) @(negedge clk);
        chk("R8 running before disable", busy, 1);
        wr(5'h00, 16'h0140);
        @(negedge clk);
        chk("R8 stopped", busy, 0);
        seen = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (expired) seen = 1'b1;
        end
        chk("R8 no expiry after stop", seen, 0);

        finish_run();
    end

endmodule